// File: doc/BRIEF.md
# Serially Configured Logic Cell

A small programmable logic cell with three user inputs and two user outputs. The inputs form the address of a lookup table that holds one 8-entry truth table per output. Each output can be taken straight from its table, or from a flip-flop that captured the table value on the previous clock edge.

The truth tables and the two output-mode bits are not written through a parallel port. They sit in one shift register that is loaded one bit per clock while the shift enable is high. The last bit of the chain is driven on a serial output, so several cells can be joined into a single long configuration chain.

Reset clears only the output flip-flops. The configuration survives a reset. Reset is asserted asynchronously and released synchronously, two clock edges after the reset pin goes high.

Top module: `cfg_logic_cell`

## Requirements
- R1: With a loaded configuration, the table value for output k is the stored bit at address `lin` (lin[2] is the address MSB). Output k's 8 table bits occupy chain positions 2+8k (address 0) up to 9+8k (address 7).
- R2: When output k's mode bit is 0 (bypass) and shifting is off, `lout[k]` follows the table value in the same cycle.
- R3: Each clock edge with `shift_en` high moves the chain up one position and loads `cfg_in` into position 0. `cfg_out` shows position 17, so a bit reaches `cfg_out` 18 shifts after it enters. A word shifted MSB first lands as {table1[7:0], table0[7:0], mode1, mode0}.
- R4: When output k's mode bit (chain position k) is 1, `lout[k]` shows a flip-flop that captured the table value at the previous edge with `shift_en` low.
- R5: Loading table0 = 0,1,1,0,1,0,0,1 and table1 = 0,0,0,1,0,1,1,1 for addresses 0 to 7 makes the cell a full adder: `lout[0]` is the sum and `lout[1]` the carry of the three input bits.
- R6: While `shift_en` is high the output flip-flops hold their value. While it is low the chain does not change.
- R7: `rst_n` low clears both output flip-flops at once. They stay cleared until the second clock edge after `rst_n` returns high. Reset does not change the chain contents.
- R8: An input that the loaded table does not depend on has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the output flip-flops |
| shift_en | input | 1 | Shift the configuration chain by one bit per clock |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (last chain bit) |
| lin | input | 3 | User inputs, table address |
| lout | output | 2 | User outputs |

## Verification
The assertions assume that `rst_n` is low before the first clock edge. They also assume that the configuration chain is not read while partly loaded, which is why the capture and bypass checks give no verdict until a full word has been shifted. The stimulus starts in reset and loads a complete 18-bit word before releasing it. It drives `lin`, `shift_en` and `cfg_in` only on falling edges. It compares the outputs only in cycles with shifting off, because the outputs are not defined while the chain is moving.

// File: rtl/cfg_cell_pkg.sv
package cfg_cell_pkg;

  typedef enum logic {
    OUT_BYPASS = 1'b0,
    OUT_REG    = 1'b1
  } out_mode_e;

  function automatic int chain_bits(input int n_in, input int n_out);
    return (2 ** n_in) * n_out + n_out;
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int LEN = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           sdi,
  output logic [LEN-1:0] cfg_q,
  output logic           sdo
);

  logic [LEN-1:0] cfg_d;

  always_comb begin
    if (shift_en) begin
      cfg_d = {cfg_q[LEN-2:0], sdi};
    end else begin
      cfg_d = cfg_q;
    end
  end

  // Configuration storage carries no reset by intent.
  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
  end

  assign sdo = cfg_q[LEN-1];

  // R3: serial bit enters at position 0
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> cfg_q[0] == $past(sdi));

  // R3: far end takes over its neighbour
  a_r3_far_end: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sdo == $past(cfg_q[LEN-2]));

  // R6: chain frozen without shift enable
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_lut.sv
module cfg_lut #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  localparam int DEPTH = 2 ** N_IN
) (
  input  logic [N_OUT*DEPTH-1:0] tbl,
  input  logic [N_IN-1:0]        addr,
  output logic [N_OUT-1:0]       lut_y
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [DEPTH-1:0] row;
    assign row      = tbl[k*DEPTH +: DEPTH];
    assign lut_y[k] = row[addr];
  end

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_cell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  input  logic mode,
  output logic y
);

  logic ff_q;
  logic ff_d;
  logic ff_en;

  assign ff_en = !hold;

  always_comb begin
    if (ff_en) begin
      ff_d = d;
    end else begin
      ff_d = ff_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else begin
      ff_q <= ff_d;
    end
  end

  assign y = (out_mode_e'(mode) == OUT_REG) ? ff_q : d;

  // R6: flip-flop holds while the chain shifts
  a_r6_ff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(ff_q));

  // R4: flip-flop captures the table value
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> ff_q == $past(d));

  // R7: flip-flop cleared while reset is in effect
  a_r7_clear: assert property (@(posedge clk)
    !rst_n |-> ff_q == 1'b0);

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cfg_cell_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             cfg_in,
  output logic             cfg_out,
  input  logic [N_IN-1:0]  lin,
  output logic [N_OUT-1:0] lout
);

  localparam int DEPTH   = 2 ** N_IN;
  localparam int TBL_LEN = DEPTH * N_OUT;
  localparam int LEN     = chain_bits(N_IN, N_OUT);

  logic             rst_sync_n;
  logic [LEN-1:0]   cfg_q;
  logic [N_OUT-1:0] lut_y;

  cfg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfg_shift_chain #(.LEN(LEN)) i_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sdi      (cfg_in),
    .cfg_q    (cfg_q),
    .sdo      (cfg_out)
  );

  cfg_lut #(.N_IN(N_IN), .N_OUT(N_OUT)) i_lut (
    .tbl   (cfg_q[LEN-1 -: TBL_LEN]),
    .addr  (lin),
    .lut_y (lut_y)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_stage
    cfg_out_stage i_stage (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .hold  (shift_en),
      .d     (lut_y[k]),
      .mode  (cfg_q[k]),
      .y     (lout[k])
    );
  end

endmodule

// File: tb/test_cfg_logic_cell.sv
`timescale 1ns/1ps
module test_cfg_logic_cell;

  localparam int NI  = 3;
  localparam int NO  = 2;
  localparam int DEP = 8;
  localparam int LEN = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          shift_en;
  logic          cfg_in;
  logic          cfg_out;
  logic [NI-1:0] lin;
  logic [NO-1:0] lout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_logic_cell i_cfg_logic_cell (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .lin(lin), .lout(lout)
  );

  // Reference model
  bit mq[$];
  bit mff[NO];
  int rel_cnt = 0;

  function automatic bit tbl_bit(int k, int a);
    return mq[2 + DEP*k + a];
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt = 0;
      foreach (mff[k]) mff[k] = 1'b0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
      foreach (mff[k]) mff[k] = 1'b0;
    end else if (!shift_en && mq.size() == LEN) begin
      foreach (mff[k]) mff[k] = tbl_bit(k, int'(lin));
    end
    if (shift_en) begin
      mq.push_front(cfg_in);
      if (mq.size() > LEN) void'(mq.pop_back());
    end
    #1;
    if (mq.size() == LEN) begin
      check("R3 cfg_out", cfg_out, mq[LEN-1]);
      if (!shift_en) begin
        for (int k = 0; k < NO; k++) begin
          if (mq[k]) check("R4 registered", lout[k], mff[k]);
          else       check("R2 bypass", lout[k], tbl_bit(k, int'(lin)));
        end
      end
    end
  end

  task automatic load(input logic [LEN-1:0] w);
    for (int i = LEN-1; i >= 0; i--) begin
      @(negedge clk);
      shift_en = 1'b1;
      cfg_in   = w[i];
    end
    @(negedge clk);
    shift_en = 1'b0;
    cfg_in   = 1'b0;
  endtask

  task automatic run_random(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lin = NI'($urandom);
    end
  endtask

  logic [7:0] sum_tbl  = 8'h96;
  logic [7:0] cy_tbl   = 8'hE8;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shift_en = 1'b0; cfg_in = 1'b0; lin = '0;
    repeat (2) @(negedge clk);
    // R7: load during reset, registered outputs stay cleared
    load({cy_tbl, sum_tbl, 2'b11});
    lin = 3'b111;
    #1;
    check("R7 reset state out0", lout[0], 1'b0);
    check("R7 reset state out1", lout[1], 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 release delay out0", lout[0], 1'b0);
    run_random(20);

    // R1 and R5: full adder in bypass mode, expected from arithmetic
    load({cy_tbl, sum_tbl, 2'b00});
    for (int a = 0; a < DEP; a++) begin
      @(negedge clk);
      lin = NI'(a);
      #1;
      check("R5 sum R1", lout[0], 1'(a[0] + a[1] + a[2]));
      check("R5 carry R1", lout[1], (a[0] + a[1] + a[2]) >= 2);
    end

    // R4: registered mode, then mixed modes
    load({8'h3C, 8'h5A, 2'b11});
    run_random(20);
    load({8'h81, 8'h7E, 2'b01});
    run_random(20);
    load({8'hC3, 8'h18, 2'b10});
    run_random(20);

    // R8: out0 depends only on lin[0], out1 only on lin[2]
    load({8'hF0, 8'hAA, 2'b00});
    for (int a = 0; a < DEP; a++) begin
      @(negedge clk);
      lin = NI'(a);
      #1;
      check("R8 unused inputs out0", lout[0], a[0]);
      check("R8 unused inputs out1", lout[1], a[2]);
    end

    // R6: registered value held across a reload
    load({8'hFF, 8'hFF, 2'b11});
    @(negedge clk); lin = 3'b000;
    @(negedge clk);
    #1;
    check("R6 pre-shift out0", lout[0], 1'b1);
    load({8'h00, 8'h00, 2'b11});
    #1;
    check("R6 held through shift", lout[0], 1'b1);
    check("R6 held through shift out1", lout[1], 1'b1);
    run_random(5);

    // R7: mid-run reset keeps configuration
    load({cy_tbl, sum_tbl, 2'b10});
    @(negedge clk); lin = 3'b011;
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R7 async clear out1", lout[1], 1'b0);
    check("R7 config kept out0", lout[0], 1'b0);
    @(negedge clk); lin = 3'b001;
    #1;
    check("R7 config kept sum", lout[0], 1'b1);
    @(negedge clk); rst_n = 1'b1;
    run_random(15);

    // R3: push a further word to stream the old one out of cfg_out
    load({8'h12, 8'h34, 2'b00});
    run_random(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule